// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block is a supervisory timer that counts ticks from a slow (about 31 kHz) free-running oscillator. It raises a time-out event when software fails to clear it in time. The tick count that ends a period is a power of two. A period select picks it, giving about 1.024 ms at the shortest setting and about 268 s at the longest. The prescaler is private to the block and shares nothing with any general-purpose timer. A 2-bit mode field sets when the timer may run: never, under the control of a software enable bit, only while the core is awake, or at all times.

A time-out while the core is awake produces a one-cycle reset request. A time-out while the core sleeps produces a one-cycle wake pulse. Either event sets a sticky status flag, which a clear strobe removes. The counter is forced to zero by a clear strobe, by entry into sleep, by the timer being disabled, and for as long as the oscillator start-up timer is active. Counting resumes from zero once that start-up timer has expired, if the mode allows it.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reset request, wake pulse and status flag are low and the counter is zero. With mode 11 and select 0, the first event therefore comes on the 2^BASE_EXP-th tick.
- R2: With counting enabled from a zero count, the event occurs on exactly the 2^(n+BASE_EXP)-th tick, where n is the period select value in 0..MAX_SEL.
- R3: A period select value above MAX_SEL behaves exactly as MAX_SEL.
- R4: Mode 00 never produces an event. Mode 01 counts only while the software enable is 1, and a 0 on that enable holds the counter at zero.
- R5: Mode 10 counts only while sleep_i is 0, so no event occurs during sleep. Mode 11 counts during sleep as well, and its time-out then wakes the core.
- R6: While ost_busy_i is 1 the counter is held at zero and no event occurs. After it falls, a full period is counted from zero.
- R7: A clear strobe zeroes the counter and the status flag. A clear in the same cycle as a tick wins, and that tick is not counted.
- R8: A rising edge of sleep_i (sleep entry) zeroes the counter.
- R9: A time-out with sleep_i at 0 gives a reset request one cycle wide. With sleep_i at 1 it gives a wake pulse one cycle wide instead. The two are never high together.
- R10: Any event sets the status flag, which stays at 1 until a clear strobe or reset.
- R11: After a time-out the counter restarts from zero, so the next event follows one full period later.
- R12: Disabling the timer through the mode field zeroes the counter, so re-enabling it gives a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe per slow-oscillator period |
| mode_i | input | 2 | Mode: 00 off, 01 software-enabled, 10 on while awake, 11 always on |
| sw_en_i | input | 1 | Software enable, used in mode 01 |
| period_sel_i | input | PSEL_W | Period select n; period is 2^(n+BASE_EXP) ticks |
| clr_i | input | 1 | Clear strobe (counter and status flag) |
| sleep_i | input | 1 | Core is asleep |
| ost_busy_i | input | 1 | Oscillator start-up timer is active |
| rst_req_o | output | 1 | One-cycle reset request on an awake time-out |
| wake_o | output | 1 | One-cycle wake pulse on a time-out during sleep |
| timeout_flag_o | output | 1 | Sticky time-out status |

## Verification
The bench uses a reduced configuration (BASE_EXP 1, MAX_SEL 4, 3-bit select). Every select value 0..7 is swept under always-on mode, and the number of ticks to each event is counted. This separates a wrong exponent, a missing clamp and an off-by-one at the terminal count. Back-to-back periods show whether the counter restarts cleanly after a time-out. Each zeroing source (clear, clear coincident with a tick, sleep entry, start-up hold, mode disable) is applied after a partial count, so a source that fails to zero the counter shows up as an early event. The four modes are each tried asleep and awake, with both enable values, to tell a reset request from a wake pulse and to confirm that gated modes stay silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF    = 2'b00,
    WD_SW     = 2'b01,
    WD_AWAKE  = 2'b10,
    WD_ALWAYS = 2'b11
  } wd_mode_e;
endpackage

// File: rtl/wdog_gate.sv
module wdog_gate
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sw_en_i,
  input  logic       sleep_i,
  input  logic       ost_busy_i,
  input  logic       clr_i,
  output logic       run_o,
  output logic       zap_o
);
  wd_mode_e mode;
  logic     en;
  logic     sleep_q;

  assign mode = wd_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      WD_OFF:    en = 1'b0;
      WD_SW:     en = sw_en_i;
      WD_AWAKE:  en = ~sleep_i;
      WD_ALWAYS: en = 1'b1;
      default:   en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else         sleep_q <= sleep_i;
  end

  assign run_o = en & ~ost_busy_i;
  // any zeroing source: strobe, sleep entry, disabled or start-up hold
  assign zap_o = clr_i | (sleep_i & ~sleep_q) | ~run_o;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PSEL_W   = 5,
  parameter int BASE_EXP = 5,
  parameter int MAX_SEL  = 18,
  localparam int CNT_W   = BASE_EXP + MAX_SEL,
  localparam int N_SEL   = MAX_SEL + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              zap_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              hit_o
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim_tbl [N_SEL];
  logic [PSEL_W-1:0] sel_eff;
  logic [CNT_W-1:0]  lim_m1;
  logic              term;

  for (genvar k = 0; k < N_SEL; k++) begin : g_lim
    assign lim_tbl[k] = CNT_W'((64'd1 << (k + BASE_EXP)) - 64'd1);
  end

  assign sel_eff = (sel_i > PSEL_W'(MAX_SEL)) ? PSEL_W'(MAX_SEL) : sel_i;
  assign lim_m1  = lim_tbl[sel_eff];
  // >= so a select lowered mid-count expires on the next tick
  assign term    = (cnt >= lim_m1);
  assign hit_o   = tick_i & ~zap_i & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (zap_i)  cnt <= '0;
    else if (tick_i) cnt <= term ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_event.sv
module wdog_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic sleep_i,
  input  logic clr_i,
  output logic rst_req_o,
  output logic wake_o,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      wake_o    <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      rst_req_o <= hit_i & ~sleep_i;
      wake_o    <= hit_i & sleep_i;
      if (clr_i)      flag_o <= 1'b0;
      else if (hit_i) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int PSEL_W   = 5,
  parameter int BASE_EXP = 5,
  parameter int MAX_SEL  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic              sw_en_i,
  input  logic [PSEL_W-1:0] period_sel_i,
  input  logic              clr_i,
  input  logic              sleep_i,
  input  logic              ost_busy_i,
  output logic              rst_req_o,
  output logic              wake_o,
  output logic              timeout_flag_o
);
  logic run, zap, hit;

  wdog_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .sw_en_i    (sw_en_i),
    .sleep_i    (sleep_i),
    .ost_busy_i (ost_busy_i),
    .clr_i      (clr_i),
    .run_o      (run),
    .zap_o      (zap)
  );

  wdog_prescaler #(
    .PSEL_W   (PSEL_W),
    .BASE_EXP (BASE_EXP),
    .MAX_SEL  (MAX_SEL)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i & run),
    .zap_i  (zap),
    .sel_i  (period_sel_i),
    .hit_o  (hit)
  );

  wdog_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .sleep_i   (sleep_i),
    .clr_i     (clr_i),
    .rst_req_o (rst_req_o),
    .wake_o    (wake_o),
    .flag_o    (timeout_flag_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       sleep_i,
  input logic       ost_busy_i,
  input logic       clr_i,
  input logic       rst_req_o,
  input logic       wake_o,
  input logic       timeout_flag_o
);
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && wake_o));
  p_rst_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_wake_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_off_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_o) |-> $past(mode_i) != 2'b00);
  p_awake_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(mode_i) != 2'b10);
  p_wake_asleep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(sleep_i));
  p_rst_awake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(sleep_i));
  p_ost_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_o) |-> !$past(ost_busy_i));
  p_flag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o || wake_o) |-> timeout_flag_o);
  p_clr_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !(rst_req_o || wake_o || timeout_flag_o));
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(timeout_flag_o) && !$past(clr_i)) |-> timeout_flag_o);
endmodule

bind wdog_timer wdog_timer_chk u_chk (.*);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int PSEL_W   = 3;
  localparam int BASE_EXP = 1;
  localparam int MAX_SEL  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic [1:0]        mode_i = 2'b11;
  logic              sw_en_i = 1'b0;
  logic [PSEL_W-1:0] period_sel_i = '0;
  logic              clr_i = 1'b0;
  logic              sleep_i = 1'b0;
  logic              ost_busy_i = 1'b0;
  logic              rst_req_o, wake_o, timeout_flag_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  wdog_timer #(.PSEL_W(PSEL_W), .BASE_EXP(BASE_EXP), .MAX_SEL(MAX_SEL)) u_dut (
    .clk_i, .rst_ni, .tick_i, .mode_i, .sw_en_i, .period_sel_i,
    .clr_i, .sleep_i, .ost_busy_i, .rst_req_o, .wake_o, .timeout_flag_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one tick cycle, then sample at the following falling edge
  task automatic do_tick(output logic r, output logic w);
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    r = rst_req_o;
    w = wake_o;
  endtask

  task automatic run_ticks(input int n);
    logic r, w;
    for (int i = 0; i < n; i++) do_tick(r, w);
  endtask

  task automatic pulse_clr();
    @(negedge clk_i) clr_i = 1'b1;
    @(negedge clk_i) clr_i = 1'b0;
  endtask

  function automatic int period(input int sel);
    int s = (sel > MAX_SEL) ? MAX_SEL : sel;
    return 1 << (s + BASE_EXP);
  endfunction

  // count ticks to the first event; checks count, kind and width
  task automatic measure(input string req, input int exp_ticks, input logic exp_wake);
    logic r, w;
    int   got = 0;
    for (int i = 1; i <= 200; i++) begin
      do_tick(r, w);
      if (r || w) begin got = i; break; end
    end
    check({req, " ticks"}, got, exp_ticks);
    check({req, " kind wake"}, int'(w), int'(exp_wake));
    check({req, " kind rst"}, int'(r), int'(!exp_wake));
    check({req, " flag R10"}, int'(timeout_flag_o), 1);
    @(negedge clk_i);
    check({req, " one-cycle R9"}, int'(rst_req_o | wake_o), 0);
  endtask

  task automatic expect_none(input string req, input int n);
    logic r, w;
    int   ev = 0;
    for (int i = 0; i < n; i++) begin
      do_tick(r, w);
      if (r || w) ev++;
    end
    check({req, " no event"}, ev, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rst_req", int'(rst_req_o), 0);
    check("R1 wake", int'(wake_o), 0);
    check("R1 flag", int'(timeout_flag_o), 0);
    rst_ni = 1'b1;
    measure("R1 first period", period(0), 1'b0);

    // R2/R3/R11 sweep of every select value
    for (int s = 0; s < (1 << PSEL_W); s++) begin
      period_sel_i = PSEL_W'(s);
      pulse_clr();
      check("R7 flag cleared", int'(timeout_flag_o), 0);
      measure((s > MAX_SEL) ? "R3 clamp" : "R2 period", period(s), 1'b0);
      measure("R11 restart", period(s), 1'b0);
    end

    period_sel_i = 3'd2;  // 8 ticks
    // R4 mode 00 and mode 01
    mode_i = 2'b00; pulse_clr();
    expect_none("R4 off", 40);
    mode_i = 2'b01; sw_en_i = 1'b0;
    expect_none("R4 sw disabled", 40);
    sw_en_i = 1'b1;
    measure("R4 sw enabled", 8, 1'b0);
    run_ticks(5); sw_en_i = 1'b0; @(negedge clk_i); sw_en_i = 1'b1;
    measure("R4 sw disable zeroes", 8, 1'b0);

    // R5 mode 10 asleep silent, mode 11 asleep wakes
    mode_i = 2'b10; sleep_i = 1'b1;
    expect_none("R5 awake-only mode asleep", 40);
    sleep_i = 1'b0; @(negedge clk_i);
    measure("R5 awake-only mode awake", 8, 1'b0);
    mode_i = 2'b11; sleep_i = 1'b1;
    measure("R5 always-on asleep wake", 8, 1'b1);
    measure("R11 wake restart", 8, 1'b1);
    sleep_i = 1'b0; pulse_clr();

    // R6 start-up hold
    run_ticks(5);
    ost_busy_i = 1'b1;
    expect_none("R6 ost hold", 20);
    ost_busy_i = 1'b0;
    measure("R6 after ost", 8, 1'b0);

    // R7 clear mid-count and coincident with tick
    run_ticks(5); pulse_clr();
    measure("R7 clear mid", 8, 1'b0);
    run_ticks(7);
    @(negedge clk_i) begin tick_i = 1'b1; clr_i = 1'b1; end
    @(negedge clk_i) begin tick_i = 1'b0; clr_i = 1'b0; end
    check("R7 clr+tick no event", int'(rst_req_o | wake_o), 0);
    measure("R7 clear wins", 8, 1'b0);

    // R8 sleep entry zeroes
    run_ticks(5);
    @(negedge clk_i) sleep_i = 1'b1;
    measure("R8 sleep entry", 8, 1'b1);
    sleep_i = 1'b0;

    // R12 mode disable zeroes
    pulse_clr(); run_ticks(5);
    mode_i = 2'b00; repeat (2) @(negedge clk_i);
    mode_i = 2'b11;
    measure("R12 re-enable", 8, 1'b0);

    // R10 flag persists without clear
    expect_none("R10 hold window", 3);
    check("R10 flag sticky", int'(timeout_flag_o), 1);
    pulse_clr();
    check("R7 flag clear", int'(timeout_flag_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule